// File: doc/BRIEF.md
# Two-Phase Non-Overlapping Pulse Generator for a Charge-Transfer Pair

This block drives the two switches of one inductor-based charge-transfer pair. During the on-phase the source-side output is high and the inductor charges from the source cell. During the off-phase the destination-side output is high and the inductor empties into the destination cell. The two outputs are never high together. A programmable dead gap with both outputs low comes before every on-phase and before every off-phase.

The on-length, off-length and gap length are separate counts of clock cycles. They are usually unequal, and the off-length is chosen by the controller so that the inductor is empty when it ends. A level `run` input starts and stops the sequence. A stop takes effect only after the off-phase in progress has finished, so the inductor is never left charged. A one-clock `cycle_done` marks the last clock of each off-phase. Each transfer pair has its own instance, and instances need no common phase reference.

The FSM has six states: IDLE, GAP_LEAD, ON, GAP_MID, OFF and FAULT. It moves through them as follows:
- start (from IDLE or FAULT, or at the end of OFF, when `run` is high and the timing is valid): to GAP_LEAD, or straight to ON when the gap is zero.
- lead-done: GAP_LEAD to ON.
- on-done: ON to GAP_MID, or straight to OFF when the gap is zero.
- mid-done: GAP_MID to OFF.
- stop: from OFF, IDLE or FAULT to IDLE when `run` is low.
- reject: to FAULT when `run` is high but a length is zero.

Top module: `pair_pwm_gen`

## Requirements
- R1: After reset, `pwm_src`, `pwm_dst`, `cycle_done` and `cfg_err` are all low.
- R2: In each cycle, `pwm_src` is high for exactly `on_cycles` consecutive clocks while `pwm_dst` is low.
- R3: After the on-phase and the middle gap, `pwm_dst` is high for exactly `off_cycles` consecutive clocks while `pwm_src` is low.
- R4: `pwm_src` and `pwm_dst` are never high in the same clock.
- R5: Exactly `dead_cycles` clocks with both outputs low separate the on-phase from the off-phase, and the off-phase from the next on-phase. A gap of zero places the phases back to back.
- R6: A cycle is decided on the clock where `run` is sampled high (in IDLE, in FAULT, or on the last clock of an off-phase). The outputs then show the lead gap, and the on-phase is always the first driven phase.
- R7: The three lengths are captured only on the deciding clock of R6. Changes at other times have no effect on the cycle in progress.
- R8: `run` low on a deciding clock stops the sequence: both outputs stay low. Lowering `run` mid-cycle still completes the on-phase, the gap and the whole off-phase.
- R9: `cycle_done` is high on exactly the final clock of each off-phase and at no other time.
- R10: When `run` is sampled high with `on_cycles` or `off_cycles` equal to zero, the block enters FAULT. In FAULT, `cfg_err` is high and both outputs are low. FAULT re-checks every clock: it starts a cycle once the lengths are valid, and returns to IDLE with `cfg_err` low once `run` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Level enable, sampled only on deciding clocks |
| on_cycles | input | W | On-phase length in clocks |
| off_cycles | input | W | Off-phase length in clocks |
| dead_cycles | input | W | Gap length in clocks (zero allowed) |
| pwm_src | output | 1 | Source-switch drive, high in the on-phase |
| pwm_dst | output | 1 | Destination-switch drive, high in the off-phase |
| cycle_done | output | 1 | High on the last clock of each off-phase |
| cfg_err | output | 1 | High while a zero length blocks the start |

## Verification
Both drive outputs and the error flag are decoded directly from the state register. A wrong state therefore appears at the ports in the very clock it is entered. A wrong counter load or decrement appears as a phase that is one or more clocks too long or too short within the same cycle. A capture made at the wrong moment appears as a wrong length for the next phase that uses the new value. The bench model predicts every clock independently from the inputs sampled on deciding clocks, so each of these errors is flagged on the clock where the first output bit differs.

// File: rtl/pair_pwm_pkg.sv
package pair_pwm_pkg;
    localparam int NUM_FIELDS = 3;
    localparam int FLD_ON     = 0;
    localparam int FLD_OFF    = 1;
    localparam int FLD_GAP    = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GAP_LEAD,
        ST_ON,
        ST_GAP_MID,
        ST_OFF,
        ST_FAULT
    } pwm_state_t;
endpackage

// File: rtl/pwm_cfg_hold.sv
module pwm_cfg_hold #(
    parameter int W  = 8,
    parameter int NF = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 capture,
    input  logic [NF-1:0][W-1:0] cfg_in,
    output logic [NF-1:0][W-1:0] cfg_eff,
    output logic [NF-1:0][W-1:0] cfg_held
);
    for (genvar i = 0; i < NF; i++) begin : g_fld
        logic [W-1:0] held_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       held_q <= '0;
            else if (capture) held_q <= cfg_in[i];
        end

        // On the capture clock the incoming value is used directly.
        assign cfg_eff[i]  = capture ? cfg_in[i] : held_q;
        assign cfg_held[i] = held_q;
    end
endmodule

// File: rtl/pwm_phase_timer.sv
module pwm_phase_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_len,
    output logic         expired
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt_q <= '0;
        else if (load)         cnt_q <= load_len - ONE;
        else if (cnt_q != '0)  cnt_q <= cnt_q - ONE;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/pair_pwm_gen.sv
module pair_pwm_gen
    import pair_pwm_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] on_cycles,
    input  logic [W-1:0] off_cycles,
    input  logic [W-1:0] dead_cycles,
    output logic         pwm_src,
    output logic         pwm_dst,
    output logic         cycle_done,
    output logic         cfg_err
);
    pwm_state_t state_q, state_d;

    logic [NUM_FIELDS-1:0][W-1:0] cfg_bus, cfg_eff, cfg_held;
    logic         decide, expired, t_load, timing_ok;
    logic [W-1:0] t_len;
    logic [W-1:0] len_on, len_off, len_gap;

    assign cfg_bus = {dead_cycles, off_cycles, on_cycles};
    assign len_on  = cfg_eff[FLD_ON];
    assign len_off = cfg_eff[FLD_OFF];
    assign len_gap = cfg_eff[FLD_GAP];

    // A deciding clock: waiting states, or the final clock of the off-phase.
    assign decide    = (state_q == ST_IDLE) || (state_q == ST_FAULT) ||
                       ((state_q == ST_OFF) && expired);
    assign timing_ok = (len_on != '0) && (len_off != '0);

    pwm_cfg_hold #(.W(W), .NF(NUM_FIELDS)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (decide),
        .cfg_in   (cfg_bus),
        .cfg_eff  (cfg_eff),
        .cfg_held (cfg_held)
    );

    pwm_phase_timer #(.W(W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_len (t_len),
        .expired  (expired)
    );

    // Next-state and timer-load decisions.
    always_comb begin
        state_d = state_q;
        t_load  = 1'b0;
        t_len   = len_on;
        unique case (state_q)
            ST_IDLE, ST_FAULT, ST_OFF: begin
                if ((state_q != ST_OFF) || expired) begin
                    if (!run) begin
                        state_d = ST_IDLE;
                    end else if (!timing_ok) begin
                        state_d = ST_FAULT;
                    end else if (len_gap != '0) begin
                        state_d = ST_GAP_LEAD;
                        t_load  = 1'b1;
                        t_len   = len_gap;
                    end else begin
                        state_d = ST_ON;
                        t_load  = 1'b1;
                        t_len   = len_on;
                    end
                end
            end
            ST_GAP_LEAD: begin
                if (expired) begin
                    state_d = ST_ON;
                    t_load  = 1'b1;
                    t_len   = len_on;
                end
            end
            ST_ON: begin
                if (expired) begin
                    t_load = 1'b1;
                    if (len_gap != '0) begin
                        state_d = ST_GAP_MID;
                        t_len   = len_gap;
                    end else begin
                        state_d = ST_OFF;
                        t_len   = len_off;
                    end
                end
            end
            ST_GAP_MID: begin
                if (expired) begin
                    state_d = ST_OFF;
                    t_load  = 1'b1;
                    t_len   = len_off;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        pwm_src    = 1'b0;
        pwm_dst    = 1'b0;
        cycle_done = 1'b0;
        cfg_err    = 1'b0;
        unique case (state_q)
            ST_ON:    pwm_src = 1'b1;
            ST_OFF: begin
                pwm_dst    = 1'b1;
                cycle_done = expired;
            end
            ST_FAULT: cfg_err = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/pair_pwm_chk.sv
module pair_pwm_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         run,
    input logic         pwm_src,
    input logic         pwm_dst,
    input logic         cycle_done,
    input logic         cfg_err,
    input logic [W-1:0] gap_held
);
    p_no_overlap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(pwm_src && pwm_dst));

    p_gap_after_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(pwm_src) && (gap_held != '0)) |-> !pwm_dst);

    p_done_in_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_done |-> pwm_dst);

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_done |=> !cycle_done);

    p_stop_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_done && !run) |=> (!pwm_src && !pwm_dst && !cfg_err));

    p_fault_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (!pwm_src && !pwm_dst && !cycle_done));
endmodule

bind pair_pwm_gen pair_pwm_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .pwm_src    (pwm_src),
    .pwm_dst    (pwm_dst),
    .cycle_done (cycle_done),
    .cfg_err    (cfg_err),
    .gap_held   (cfg_held[pair_pwm_pkg::FLD_GAP])
);

// File: tb/tb_pair_pwm_gen.sv
module tb_pair_pwm_gen;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         run = 1'b0;
    logic [W-1:0] on_cycles = '0, off_cycles = '0, dead_cycles = '0;
    logic         pwm_src, pwm_dst, cycle_done, cfg_err;

    int    n_chk = 0;
    int    n_fail = 0;
    string scen = "R1";
    bit    done_flag = 1'b0;

    logic [1:0] q[$];   // {src, dst} expected per clock
    bit         m_err = 1'b0;

    always #10 clk = ~clk;

    pair_pwm_gen #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n), .run(run),
        .on_cycles(on_cycles), .off_cycles(off_cycles), .dead_cycles(dead_cycles),
        .pwm_src(pwm_src), .pwm_dst(pwm_dst), .cycle_done(cycle_done), .cfg_err(cfg_err)
    );

    task automatic chk(input logic act, input logic exp, input string rq, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s (scenario %s) %s actual=%0b expected=%0b at %0t",
                     rq, scen, what, act, exp, $time);
        end
    endtask

    // Reference model: compare this clock, then predict the next.
    always @(negedge clk) begin
        logic [1:0] e;
        int sz;
        if (!done_flag) begin
            e = (q.size() > 0) ? q[0] : 2'b00;
            chk(pwm_src, e[1], "R2", "pwm_src");
            chk(pwm_dst, e[0], "R3", "pwm_dst");
            chk(cycle_done, q.size() == 1, "R9", "cycle_done");
            chk(cfg_err, m_err, "R10", "cfg_err");
            chk(pwm_src & pwm_dst, 1'b0, "R4", "overlap");
            if (!rst_n) begin
                q.delete();
                m_err = 1'b0;
            end else begin
                sz = q.size();
                if (sz > 0) void'(q.pop_front());
                if (sz <= 1) begin
                    if (!run) m_err = 1'b0;
                    else if (on_cycles == 0 || off_cycles == 0) m_err = 1'b1;
                    else begin
                        m_err = 1'b0;
                        for (int i = 0; i < int'(dead_cycles); i++) q.push_back(2'b00);
                        for (int i = 0; i < int'(on_cycles); i++)   q.push_back(2'b10);
                        for (int i = 0; i < int'(dead_cycles); i++) q.push_back(2'b00);
                        for (int i = 0; i < int'(off_cycles); i++)  q.push_back(2'b01);
                    end
                end
            end
        end
    end

    task automatic cfg(input int a, input int b, input int g);
        @(posedge clk); #1;
        on_cycles = W'(a); off_cycles = W'(b); dead_cycles = W'(g);
    endtask

    task automatic set_run(input logic v);
        @(posedge clk); #1;
        run = v;
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic finish_run();
        done_flag = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog (scenario %s) actual=timeout expected=completion", scen);
        finish_run();
    end

    initial begin
        // R1: reset state
        scen = "R1";
        wait_clk(4);
        #1 rst_n = 1'b1;
        wait_clk(3);

        // R6: start, lead gap then on-phase; R2 R3 R5 R9 lengths
        scen = "R6";
        cfg(3, 5, 2);
        set_run(1'b1);
        wait_clk(5);
        // R7: mid-cycle change only applies from the next cycle
        scen = "R7";
        cfg(6, 2, 1);
        wait_clk(30);
        // R8: stop in the middle of a cycle completes the off-phase
        scen = "R8";
        wait_clk(3);
        set_run(1'b0);
        wait_clk(25);

        // R5: zero gap, phases back to back
        scen = "R5";
        cfg(4, 2, 0);
        set_run(1'b1);
        wait_clk(25);
        set_run(1'b0);
        wait_clk(12);

        // R10: zero lengths raise the error flag and block the start
        scen = "R10";
        cfg(0, 4, 1);
        set_run(1'b1);
        wait_clk(6);
        cfg(3, 0, 1);
        wait_clk(4);
        cfg(2, 3, 1);
        wait_clk(20);
        cfg(0, 3, 1);
        wait_clk(20);
        set_run(1'b0);
        wait_clk(5);

        // R2: minimal and long asymmetric timings
        scen = "R2";
        cfg(1, 1, 1);
        set_run(1'b1);
        wait_clk(20);
        cfg(20, 7, 3);
        wait_clk(100);
        set_run(1'b0);
        wait_clk(60);

        // R9: one-clock phases with no gap
        scen = "R9";
        cfg(1, 1, 0);
        set_run(1'b1);
        wait_clk(20);
        set_run(1'b0);
        wait_clk(10);

        finish_run();
    end
endmodule